// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from reset to an operational state without software involvement. After a synchronous reset it raises the clock-enable, termination and device-reset-release lines in one cycle. It then waits out the power-up interval and steps through a fixed script of commands. The script is two precharge-all commands, two mode-register loads and two auto-refreshes. The first mode load carries the DLL reset bit and the second does not, and the refreshes sit between the two loads. Each command occupies the single command phase for exactly one cycle. It carries its own row and bank address, and a programmable number of deselect cycles follows where the script calls for one.

When the last wait expires, the sequencer raises a completion flag and holds it. From then on the pin mux forwards the command, address and bank inputs of a downstream memory controller, and the sequencer issues nothing until it is reset again. All pins leave the block through an optional register stage, so the sequencer and the controller reach the pins with the same latency.

Top module: `sdinit_seq`

## Requirements
- R1: While reset is held, the command pins read deselect (`mem_cmd_n` = 4'b1111). Address and bank are 0, and clock-enable, termination, reset-release, `bus_sel` and `init_done` are all low.
- R2: Clock-enable, termination and reset-release rise in the same cycle. They then stay high until the next reset.
- R3: The first command is a precharge-all. It appears exactly `T_POWERUP` cycles after the control lines rise.
- R4: The commands come in this order, each with bank 0. Precharge-all (`mem_cmd_n` = 4'b0010, order {cs,ras,cas,we}) with address 0x400. Mode load (4'b0000) with 0x120, meaning DLL reset, CAS latency 2 and burst length 1. Precharge-all with 0x400. Auto-refresh (4'b0001) with address 0, issued twice. Mode load with 0x020.
- R5: Each command is driven for one cycle only. Every other cycle before completion is deselect with address 0 and bank 0.
- R6: The spacing between consecutive command cycles is as follows. Precharge to mode load is 1. First mode load to second precharge is `T_MODE`+1. Second precharge to first refresh is 1. Refresh to refresh is `T_REFRESH`+1. Second refresh to final mode load is `T_REFRESH`+1.
- R7: `init_done` rises exactly `T_MODE`+1 cycles after the final mode load. It stays high until reset.
- R8: Once `bus_sel` is high, the pins carry the downstream `ctl_*` inputs, with one cycle of latency when `OUT_REG` is 1.
- R9: A reset in the middle of the sequence returns every pin to the R1 state. After release, the whole script runs again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_cmd_n | input | 4 | Downstream controller command {cs_n,ras_n,cas_n,we_n} |
| ctl_addr | input | ADDR_W | Downstream controller address |
| ctl_bank | input | BANK_W | Downstream controller bank |
| mem_cmd_n | output | 4 | Command pins {cs_n,ras_n,cas_n,we_n}, active low |
| mem_addr | output | ADDR_W | Address pins |
| mem_bank | output | BANK_W | Bank pins |
| mem_cke | output | 1 | Clock enable |
| mem_odt | output | 1 | On-die termination |
| mem_reset_n | output | 1 | Device reset release |
| bus_sel | output | 1 | High when the pins carry the downstream controller |
| init_done | output | 1 | Initialization complete, held |

## Verification
The pin assertions assume that reset is synchronous and held for at least one clock edge. They also assume that no two identical commands are scheduled back to back, which the fixed script guarantees. The downstream inputs are never inspected while the sequencer owns the bus. The bench therefore keeps `ctl_cmd_n` at deselect until `bus_sel` has risen and only then walks it through distinct patterns. The waits are shortened through parameters, so the full script and its spacing stay visible within a short run. One reset is applied in the middle of the power-up wait and another after completion.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

   // Asserted-high view of the command lines; the pin stage inverts them.
   typedef struct packed {
      logic cs;
      logic ras;
      logic cas;
      logic we;
   } cmd_flags_t;

   localparam cmd_flags_t CMD_DESEL  = '{cs: 1'b0, ras: 1'b0, cas: 1'b0, we: 1'b0};
   localparam cmd_flags_t CMD_PREALL = '{cs: 1'b1, ras: 1'b1, cas: 1'b0, we: 1'b1};
   localparam cmd_flags_t CMD_MODE   = '{cs: 1'b1, ras: 1'b1, cas: 1'b1, we: 1'b1};
   localparam cmd_flags_t CMD_AREF   = '{cs: 1'b1, ras: 1'b1, cas: 1'b1, we: 1'b0};

   // Script positions; the order is the behaviour.
   typedef enum logic [2:0] {
      ST_POWER    = 3'd0,
      ST_PALL_A   = 3'd1,
      ST_MODE_DLL = 3'd2,
      ST_PALL_B   = 3'd3,
      ST_AREF_A   = 3'd4,
      ST_AREF_B   = 3'd5,
      ST_MODE_RUN = 3'd6,
      ST_DONE     = 3'd7
   } step_e;

   typedef enum logic {
      PH_ISSUE = 1'b0,
      PH_WAIT  = 1'b1
   } phase_e;

   // Mode word fields
   localparam int MR_CL_POS   = 4;
   localparam int MR_DLL_POS  = 8;
   localparam int MR_CL_VAL   = 2;
   localparam int MR_BL_CODE  = 0;
   localparam int AP_ALL_POS  = 10;

endpackage

// File: rtl/sdinit_script.sv
module sdinit_script
   import sdinit_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int BANK_W    = 2,
   parameter int CNT_W     = 15,
   parameter int T_POWERUP = 20000,
   parameter int T_MODE    = 200,
   parameter int T_REFRESH = 4
) (
   input  step_e              step,
   output cmd_flags_t         flags,
   output logic [ADDR_W-1:0]  addr,
   output logic [BANK_W-1:0]  bank,
   output logic [CNT_W-1:0]   wait_len
);

   localparam logic [ADDR_W-1:0] A_PALL     = ADDR_W'(1 << AP_ALL_POS);
   localparam logic [ADDR_W-1:0] A_MODE_RUN = ADDR_W'((MR_CL_VAL << MR_CL_POS) | MR_BL_CODE);
   localparam logic [ADDR_W-1:0] A_MODE_DLL = A_MODE_RUN | ADDR_W'(1 << MR_DLL_POS);
   localparam logic [CNT_W-1:0]  W_POWER    = CNT_W'(T_POWERUP);
   localparam logic [CNT_W-1:0]  W_MODE     = CNT_W'(T_MODE);
   localparam logic [CNT_W-1:0]  W_REF      = CNT_W'(T_REFRESH);

   assign bank = '0;

   always_comb begin
      flags    = CMD_DESEL;
      addr     = '0;
      wait_len = '0;
      unique case (step)
         ST_POWER:    begin wait_len = W_POWER; end
         ST_PALL_A,
         ST_PALL_B:   begin flags = CMD_PREALL; addr = A_PALL; end
         ST_MODE_DLL: begin flags = CMD_MODE; addr = A_MODE_DLL; wait_len = W_MODE; end
         ST_AREF_A,
         ST_AREF_B:   begin flags = CMD_AREF; wait_len = W_REF; end
         ST_MODE_RUN: begin flags = CMD_MODE; addr = A_MODE_RUN; wait_len = W_MODE; end
         ST_DONE:     begin end
         default:     begin end
      endcase
   end

endmodule

// File: rtl/sdinit_pin_stage.sv
module sdinit_pin_stage
   import sdinit_pkg::*;
#(
   parameter int ADDR_W  = 13,
   parameter int BANK_W  = 2,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_ctl,
   input  cmd_flags_t        seq_flags,
   input  logic [ADDR_W-1:0] seq_addr,
   input  logic [BANK_W-1:0] seq_bank,
   input  logic              ctrl_on,
   input  logic              ctl_valid_done,
   input  logic [3:0]        ctl_cmd_n,
   input  logic [ADDR_W-1:0] ctl_addr,
   input  logic [BANK_W-1:0] ctl_bank,
   output logic [3:0]        mem_cmd_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BANK_W-1:0] mem_bank,
   output logic              mem_cke,
   output logic              mem_odt,
   output logic              mem_reset_n,
   output logic              bus_sel,
   output logic              init_done
);

   logic [3:0]        nxt_cmd_n;
   logic [ADDR_W-1:0] nxt_addr;
   logic [BANK_W-1:0] nxt_bank;

   always_comb begin
      if (sel_ctl) begin
         nxt_cmd_n = ctl_cmd_n;
         nxt_addr  = ctl_addr;
         nxt_bank  = ctl_bank;
      end else begin
         nxt_cmd_n = ~{seq_flags.cs, seq_flags.ras, seq_flags.cas, seq_flags.we};
         nxt_addr  = seq_addr;
         nxt_bank  = seq_bank;
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               mem_cmd_n   <= 4'hF;
               mem_addr    <= '0;
               mem_bank    <= '0;
               mem_cke     <= 1'b0;
               mem_odt     <= 1'b0;
               mem_reset_n <= 1'b0;
               bus_sel     <= 1'b0;
               init_done   <= 1'b0;
            end else begin
               mem_cmd_n   <= nxt_cmd_n;
               mem_addr    <= nxt_addr;
               mem_bank    <= nxt_bank;
               mem_cke     <= ctrl_on;
               mem_odt     <= ctrl_on;
               mem_reset_n <= ctrl_on;
               bus_sel     <= sel_ctl;
               init_done   <= ctl_valid_done;
            end
         end
      end else begin : g_comb
         assign mem_cmd_n   = nxt_cmd_n;
         assign mem_addr    = nxt_addr;
         assign mem_bank    = nxt_bank;
         assign mem_cke     = ctrl_on;
         assign mem_odt     = ctrl_on;
         assign mem_reset_n = ctrl_on;
         assign bus_sel     = sel_ctl;
         assign init_done   = ctl_valid_done;
      end
   endgenerate

endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
   import sdinit_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int BANK_W    = 2,
   parameter int T_POWERUP = 20000,
   parameter int T_MODE    = 200,
   parameter int T_REFRESH = 4,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [3:0]        ctl_cmd_n,
   input  logic [ADDR_W-1:0] ctl_addr,
   input  logic [BANK_W-1:0] ctl_bank,
   output logic [3:0]        mem_cmd_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BANK_W-1:0] mem_bank,
   output logic              mem_cke,
   output logic              mem_odt,
   output logic              mem_reset_n,
   output logic              bus_sel,
   output logic              init_done
);

   localparam int T_MAX_A = (T_POWERUP > T_MODE) ? T_POWERUP : T_MODE;
   localparam int T_MAX   = (T_MAX_A > T_REFRESH) ? T_MAX_A : T_REFRESH;
   localparam int CNT_W   = (T_MAX < 2) ? 1 : $clog2(T_MAX + 1);

   generate
      if (ADDR_W < AP_ALL_POS + 1) begin : g_bad_addr
         $error("sdinit_seq: ADDR_W too narrow for the precharge-all bit");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $error("sdinit_seq: BANK_W must be at least 1");
      end
      if (T_POWERUP < 0 || T_MODE < 0 || T_REFRESH < 0) begin : g_bad_wait
         $error("sdinit_seq: wait lengths must be non-negative");
      end
   endgenerate

   step_e             step;
   phase_e            phase;
   logic [CNT_W-1:0]  cnt;
   logic              ctrl_on;

   cmd_flags_t        scr_flags;
   logic [ADDR_W-1:0] scr_addr;
   logic [BANK_W-1:0] scr_bank;
   logic [CNT_W-1:0]  scr_wait;

   cmd_flags_t        seq_flags;
   logic [ADDR_W-1:0] seq_addr;
   logic [BANK_W-1:0] seq_bank;
   logic              issuing;
   logic              seq_done;

   sdinit_script #(
      .ADDR_W    (ADDR_W),
      .BANK_W    (BANK_W),
      .CNT_W     (CNT_W),
      .T_POWERUP (T_POWERUP),
      .T_MODE    (T_MODE),
      .T_REFRESH (T_REFRESH)
   ) u_script (
      .step     (step),
      .flags    (scr_flags),
      .addr     (scr_addr),
      .bank     (scr_bank),
      .wait_len (scr_wait)
   );

   assign seq_done = (step == ST_DONE);
   assign issuing  = (phase == PH_ISSUE) && !seq_done;
   assign seq_flags = issuing ? scr_flags : CMD_DESEL;
   assign seq_addr  = issuing ? scr_addr  : '0;
   assign seq_bank  = issuing ? scr_bank  : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         step    <= ST_POWER;
         phase   <= PH_ISSUE;
         cnt     <= '0;
         ctrl_on <= 1'b0;
      end else begin
         unique case (phase)
            PH_ISSUE: begin
               if (!seq_done) begin
                  if (step == ST_POWER) ctrl_on <= 1'b1;
                  if (scr_wait == '0) begin
                     step <= step_e'(step + 3'd1);
                  end else begin
                     phase <= PH_WAIT;
                     cnt   <= scr_wait - 1'b1;
                  end
               end
            end
            PH_WAIT: begin
               if (cnt == '0) begin
                  phase <= PH_ISSUE;
                  step  <= step_e'(step + 3'd1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: phase <= PH_ISSUE;
         endcase
      end
   end

   sdinit_pin_stage #(
      .ADDR_W  (ADDR_W),
      .BANK_W  (BANK_W),
      .OUT_REG (OUT_REG)
   ) u_pins (
      .clk            (clk),
      .rst            (rst),
      .sel_ctl        (seq_done),
      .seq_flags      (seq_flags),
      .seq_addr       (seq_addr),
      .seq_bank       (seq_bank),
      .ctrl_on        (ctrl_on),
      .ctl_valid_done (seq_done),
      .ctl_cmd_n      (ctl_cmd_n),
      .ctl_addr       (ctl_addr),
      .ctl_bank       (ctl_bank),
      .mem_cmd_n      (mem_cmd_n),
      .mem_addr       (mem_addr),
      .mem_bank       (mem_bank),
      .mem_cke        (mem_cke),
      .mem_odt        (mem_odt),
      .mem_reset_n    (mem_reset_n),
      .bus_sel        (bus_sel),
      .init_done      (init_done)
   );

   // R6: the wait counter never starts above the length the script asks for
   a_r6_cnt_in_window: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_WAIT) |-> (cnt < scr_wait));

   // R2: control lines never fall before the next reset
   a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
      mem_cke |=> mem_cke);

   // R3: no command reaches the pins while clock enable is low
   a_r3_cmd_needs_cke: assert property (@(posedge clk) disable iff (rst)
      (!bus_sel && mem_cmd_n != 4'hF) |-> mem_cke);

   // R5: a sequencer command is never repeated in the following cycle
   a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
      (!bus_sel && mem_cmd_n != 4'hF) |=> (bus_sel || mem_cmd_n != $past(mem_cmd_n)));

   // R4: the sequencer only ever addresses bank 0
   a_r4_bank_zero: assert property (@(posedge clk) disable iff (rst)
      !bus_sel |-> (mem_bank == '0));

   // R7: completion is held
   a_r7_done_hold: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   // R8: once handed over, the bus stays with the controller
   a_r8_sel_hold: assert property (@(posedge clk) disable iff (rst)
      bus_sel |=> bus_sel);

endmodule

// File: tb/tb_sdinit_seq.sv
module tb_sdinit_seq;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 13;
   localparam int BANK_W     = 2;
   localparam int T_POWERUP  = 50;
   localparam int T_MODE     = 10;
   localparam int T_REFRESH  = 4;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [3:0]        ctl_cmd_n = 4'hF;
   logic [ADDR_W-1:0] ctl_addr = '0;
   logic [BANK_W-1:0] ctl_bank = '0;
   logic [3:0]        mem_cmd_n;
   logic [ADDR_W-1:0] mem_addr;
   logic [BANK_W-1:0] mem_bank;
   logic              mem_cke, mem_odt, mem_reset_n, bus_sel, init_done;

   sdinit_seq #(
      .ADDR_W    (ADDR_W),
      .BANK_W    (BANK_W),
      .T_POWERUP (T_POWERUP),
      .T_MODE    (T_MODE),
      .T_REFRESH (T_REFRESH),
      .OUT_REG   (1'b1)
   ) dut (
      .clk         (clk),
      .rst         (rst),
      .ctl_cmd_n   (ctl_cmd_n),
      .ctl_addr    (ctl_addr),
      .ctl_bank    (ctl_bank),
      .mem_cmd_n   (mem_cmd_n),
      .mem_addr    (mem_addr),
      .mem_bank    (mem_bank),
      .mem_cke     (mem_cke),
      .mem_odt     (mem_odt),
      .mem_reset_n (mem_reset_n),
      .bus_sel     (bus_sel),
      .init_done   (init_done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      logic [3:0]        cmd;
      logic [ADDR_W-1:0] addr;
      int                gap;
      string             req;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   summary_done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic push(input logic [3:0] c, input logic [ADDR_W-1:0] a,
                       input int g, input string r);
      exp_t e;
      e.cmd = c; e.addr = a; e.gap = g; e.req = r;
      exp_q.push_back(e);
   endtask

   // Driver side: the full expected script (R3, R4, R6)
   task automatic push_script();
      push(4'b0010, 13'h400, T_POWERUP,     "R3");
      push(4'b0000, 13'h120, 1,             "R4");
      push(4'b0010, 13'h400, T_MODE + 1,    "R6");
      push(4'b0001, 13'h000, 1,             "R6");
      push(4'b0001, 13'h000, T_REFRESH + 1, "R6");
      push(4'b0000, 13'h020, T_REFRESH + 1, "R4");
   endtask

   // Monitor: pops expectations as commands appear on the pins
   int last_evt  = 0;
   bit prev_cke  = 1'b0;
   bit prev_done = 1'b0;

   always @(negedge clk) begin
      if (rst) begin
         prev_cke  <= 1'b0;
         prev_done <= 1'b0;
      end else begin
         if (mem_cke && !prev_cke) begin
            chk(mem_odt && mem_reset_n, "R2", "control lines rise together",
                {30'd0, mem_odt, mem_reset_n}, 32'h3);
            last_evt = cyc;
         end
         if (prev_cke && !mem_cke)
            chk(1'b0, "R2", "clock enable dropped", 0, 1);
         if (!bus_sel) begin
            if (mem_cmd_n != 4'hF) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R5", "unexpected extra command", mem_cmd_n, 4'hF);
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  chk(mem_cmd_n == e.cmd, "R4", "command code", mem_cmd_n, e.cmd);
                  chk(mem_addr == e.addr, "R4", "command address", mem_addr, e.addr);
                  chk(mem_bank == '0, "R4", "command bank", mem_bank, 0);
                  chk(cyc - last_evt == e.gap, e.req, "spacing before command",
                      cyc - last_evt, e.gap);
               end
               last_evt = cyc;
            end else if (mem_addr != '0 || mem_bank != '0) begin
               chk(1'b0, "R5", "idle cycle address/bank", {mem_bank, mem_addr}, 0);
            end
         end
         if (init_done && !prev_done) begin
            chk(cyc - last_evt == T_MODE + 1, "R7", "done delay after final load",
                cyc - last_evt, T_MODE + 1);
            chk(exp_q.size() == 0, "R4", "commands left unissued", exp_q.size(), 0);
         end
         if (prev_done && !init_done)
            chk(1'b0, "R7", "done dropped", 0, 1);
         prev_cke  <= mem_cke;
         prev_done <= init_done;
      end
   end

   task automatic check_reset_state(input string req);
      chk(mem_cmd_n == 4'hF, req, "reset command pins", mem_cmd_n, 4'hF);
      chk(mem_addr == '0 && mem_bank == '0, req, "reset address/bank",
          {mem_bank, mem_addr}, 0);
      chk({mem_cke, mem_odt, mem_reset_n} == 3'b000, req, "reset control lines",
          {mem_cke, mem_odt, mem_reset_n}, 0);
      chk({bus_sel, init_done} == 2'b00, req, "reset sel/done",
          {bus_sel, init_done}, 0);
   endtask

   task automatic wait_done();
      int n = 0;
      while (!init_done && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(init_done, "R7", "sequence completed", init_done, 1);
   endtask

   initial begin
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_reset_state("R1");

      // Partial run, reset inside the power-up wait (R9)
      @(posedge clk); #1 rst = 1'b0;
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(mem_cke, "R2", "control lines high during wait", mem_cke, 1);
      @(posedge clk); #1 rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_reset_state("R9");

      // Full run
      push_script();
      @(posedge clk); #1 rst = 1'b0;
      wait_done();

      // Hand-off to downstream controller (R8)
      for (int i = 0; i < 8; i++) begin
         logic [3:0]        vc;
         logic [ADDR_W-1:0] va;
         logic [BANK_W-1:0] vb;
         vc = 4'(i * 5 + 3);
         va = ADDR_W'(13'h155 + i * 97);
         vb = BANK_W'(i);
         @(posedge clk); #1;
         ctl_cmd_n = vc; ctl_addr = va; ctl_bank = vb;
         @(posedge clk);
         @(negedge clk);
         chk(mem_cmd_n == vc, "R8", "forwarded command", mem_cmd_n, vc);
         chk(mem_addr == va && mem_bank == vb, "R8", "forwarded address/bank",
             {mem_bank, mem_addr}, {vb, va});
         chk(bus_sel && init_done, "R7", "done and select held",
             {bus_sel, init_done}, 2'b11);
      end

      // Reset after completion, script restarts from the top (R9)
      @(posedge clk); #1;
      ctl_cmd_n = 4'hF; ctl_addr = '0; ctl_bank = '0;
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_reset_state("R9");
      push_script();
      @(posedge clk); #1 rst = 1'b0;
      wait_done();
      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R9", "restarted script complete", exp_q.size(), 0);

      if (!summary_done) begin
         summary_done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
      end
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
      end
      $finish;
   end

endmodule